// File: doc/BRIEF.md
# Adaptive step ADPCM nibble decoder

This block turns a stream of 4-bit adaptive differential codes into signed 16-bit sample values. Each code arrives with a one-cycle valid strobe. The block keeps a step row index between 0 and 15. The row and the low three code bits select a delta magnitude, and the top code bit gives that delta its sign. The delta is added to the running sample. After that, the same three low bits move the row index up or down, and the index is clamped to its legal range. A synchronous clear returns the decoder to its silent starting point. It is raised while the stream carries a silence block.

A small two-state controller tracks whether decoding has begun. The state names are ST_SILENT and ST_DECODE. The transitions are:
- `go` runs from ST_SILENT to ST_DECODE on a valid code without a clear.
- `hush` runs from ST_DECODE to ST_SILENT on a clear.
- `stay` holds the present state otherwise.

Reset or a clear always places the decoder in ST_SILENT, with the sample and the index at zero.

Top module: `adpcm_nibble_dec`

## Requirements
- R1: After reset, smp_out is 0 and step_idx is 0. Both stay there until the first valid code arrives.
- R2: The delta magnitude for code bits [2:0] = k comes from a fixed 16-row table. Row 0 holds 0,0,1,2,3,5,7,10 for k = 0..7, and row 15 holds 6,20,36,54,76,104,144,214. When code bit 3 is 1 the delta is negative, otherwise it is positive. The delta is added to the sample.
- R3: On a valid code, step_idx changes according to code bits [2:0], and code bit 3 has no effect on this change:
  - k = 0 or 1 gives -1.
  - k = 2 or 3 gives 0.
  - k = 4 gives +1.
  - k = 5 or 6 gives +2.
  - k = 7 gives +3.
- R4: step_idx saturates at 0 and at 15 and never leaves that range.
- R5: The delta is taken from the row in force before the index update that the same code causes.
- R6: A clear sets smp_out and step_idx to 0 on the next edge. If a clear and a valid code arrive in the same cycle, the clear wins.
- R7: Without a valid code or a clear, smp_out and step_idx keep their values.
- R8: A code sampled on a rising edge shows up on both outputs right after that edge, with no further latency.
- R9: The sample accumulates in 16-bit two's complement and wraps on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of sample and index |
| nib_vld | input | 1 | Code valid strobe |
| nib_code | input | 4 | ADPCM code; bit 3 is the sign, bits [2:0] the magnitude select |
| smp_out | output | SMP_W (16) | Signed decoded sample |
| step_idx | output | 4 | Current step row index |

## Verification
The hardest case to bring about is a particular row paired with a particular code, because the row can only be steered through earlier codes. The bench reaches each row by clearing and then sending runs of the +1 code, and only then applies the code under test. That sweep covers all 256 row and code pairs, and it also exercises the pre-update row selection. Wraparound needs a long run at the top row, so the bench holds the largest positive code at row 15 until the sample crosses full scale.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    localparam int ROWS  = 16;
    localparam int MAG_W = 8;
    localparam int DLT_W = MAG_W + 1;

    typedef enum logic [0:0] {
        ST_SILENT = 1'b0,
        ST_DECODE = 1'b1
    } dec_state_t;

    // Eight magnitudes per row, selector value k at bits [8k+7:8k].
    function automatic logic [8*MAG_W-1:0] row_mags(input logic [3:0] row);
        logic [8*MAG_W-1:0] w;
        unique case (row)
            4'd0:  w = {8'd10,  8'd7,   8'd5,  8'd3,  8'd2,  8'd1,  8'd0,  8'd0};
            4'd1:  w = {8'd13,  8'd8,   8'd6,  8'd4,  8'd3,  8'd2,  8'd1,  8'd0};
            4'd2:  w = {8'd15,  8'd10,  8'd7,  8'd5,  8'd4,  8'd2,  8'd1,  8'd0};
            4'd3:  w = {8'd19,  8'd13,  8'd9,  8'd6,  8'd4,  8'd3,  8'd1,  8'd0};
            4'd4:  w = {8'd23,  8'd15,  8'd11, 8'd8,  8'd5,  8'd3,  8'd2,  8'd0};
            4'd5:  w = {8'd29,  8'd19,  8'd14, 8'd10, 8'd7,  8'd4,  8'd2,  8'd0};
            4'd6:  w = {8'd33,  8'd22,  8'd16, 8'd12, 8'd8,  8'd5,  8'd3,  8'd0};
            4'd7:  w = {8'd43,  8'd29,  8'd20, 8'd15, 8'd10, 8'd7,  8'd4,  8'd1};
            4'd8:  w = {8'd53,  8'd35,  8'd25, 8'd18, 8'd13, 8'd8,  8'd4,  8'd1};
            4'd9:  w = {8'd64,  8'd43,  8'd31, 8'd22, 8'd16, 8'd10, 8'd6,  8'd1};
            4'd10: w = {8'd76,  8'd51,  8'd37, 8'd27, 8'd19, 8'd12, 8'd7,  8'd2};
            4'd11: w = {8'd96,  8'd64,  8'd46, 8'd34, 8'd24, 8'd16, 8'd9,  8'd2};
            4'd12: w = {8'd117, 8'd79,  8'd57, 8'd41, 8'd29, 8'd19, 8'd11, 8'd3};
            4'd13: w = {8'd143, 8'd96,  8'd69, 8'd50, 8'd36, 8'd24, 8'd13, 8'd4};
            4'd14: w = {8'd175, 8'd118, 8'd85, 8'd62, 8'd44, 8'd29, 8'd16, 8'd4};
            4'd15: w = {8'd214, 8'd144, 8'd104, 8'd76, 8'd54, 8'd36, 8'd20, 8'd6};
            default: w = '0;
        endcase
        return w;
    endfunction

    // Index movement chosen by the three magnitude bits.
    function automatic logic signed [2:0] idx_adjust(input logic [2:0] k);
        logic signed [2:0] a;
        unique case (k)
            3'd0, 3'd1: a = -3'sd1;
            3'd2, 3'd3: a = 3'sd0;
            3'd4:       a = 3'sd1;
            3'd5, 3'd6: a = 3'sd2;
            3'd7:       a = 3'sd3;
            default:    a = 3'sd0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/adpcm_delta_lut.sv
module adpcm_delta_lut
    import adpcm_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]        row,
    input  logic [3:0]              code,
    output logic signed [DLT_W-1:0] delta
);
    logic [8*MAG_W-1:0] word;
    logic [MAG_W-1:0]   mag;

    always_comb begin
        word  = row_mags(row[3:0]);
        mag   = word[code[2:0]*MAG_W +: MAG_W];
        delta = code[3] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/adpcm_index_adapt.sv
module adpcm_index_adapt
    import adpcm_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx_cur,
    input  logic [2:0]       sel,
    output logic [IDX_W-1:0] idx_nxt
);
    localparam int SUM_W   = IDX_W + 2;
    localparam int IDX_MAX = (1 << IDX_W) - 1;

    logic signed [2:0]       adj;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        adj = idx_adjust(sel);
        sum = $signed({2'b00, idx_cur}) + $signed({{(SUM_W-3){adj[2]}}, adj});
        if (sum < 0)
            idx_nxt = '0;
        else if (sum > SUM_W'(IDX_MAX))
            idx_nxt = IDX_W'(IDX_MAX);
        else
            idx_nxt = sum[IDX_W-1:0];
    end
endmodule

// File: rtl/adpcm_nibble_dec.sv
module adpcm_nibble_dec
    import adpcm_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    nib_vld,
    input  logic [3:0]              nib_code,
    output logic signed [SMP_W-1:0] smp_out,
    output logic [3:0]              step_idx
);
    localparam int IDX_W = 4;

    dec_state_t              state_q, state_d;
    logic signed [DLT_W-1:0] delta;
    logic [IDX_W-1:0]        idx_nxt;
    logic                    take;

    assign take = nib_vld && !clr;

    adpcm_delta_lut #(.IDX_W(IDX_W)) lut_i (
        .row   (step_idx),
        .code  (nib_code),
        .delta (delta)
    );

    adpcm_index_adapt #(.IDX_W(IDX_W)) adapt_i (
        .idx_cur (step_idx),
        .sel     (nib_code[2:0]),
        .idx_nxt (idx_nxt)
    );

    // Next-state logic: go, hush, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SILENT: if (take) state_d = ST_DECODE;
            ST_DECODE: if (clr)  state_d = ST_SILENT;
            default:             state_d = ST_SILENT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SILENT;
        else        state_q <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            smp_out  <= '0;
            step_idx <= '0;
        end else if (nib_vld) begin
            smp_out  <= smp_out + SMP_W'(delta);
            step_idx <= idx_nxt;
        end
    end

    AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SILENT) |-> (smp_out == '0 && step_idx == '0)); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (smp_out == '0 && step_idx == '0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nib_vld && !clr) |=> ($stable(smp_out) && $stable(step_idx))); // R7

    AST_IDX_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((int'(step_idx) - int'($past(step_idx)) >= -1) &&
                  (int'(step_idx) - int'($past(step_idx)) <= 3))); // R3

    AST_IDX_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (take && step_idx == 4'd15 && nib_code[2]) |=> (step_idx == 4'd15)); // R4

    AST_IDX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && step_idx == 4'd0 && nib_code[2:1] == 2'b00) |=> (step_idx == 4'd0)); // R4
endmodule

// File: tb/adpcm_nibble_dec_tb_top.sv
`timescale 1ns/1ps
module adpcm_nibble_dec_tb_top;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               clr;
    logic               nib_vld;
    logic [3:0]         nib_code;
    logic signed [15:0] smp_out;
    logic [3:0]         step_idx;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    logic signed [15:0] m_smp;
    int                 m_idx;
    logic [31:0]        rng = 32'h1234_5678;

    always #10 clk = ~clk;

    adpcm_nibble_dec dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .nib_vld(nib_vld),
        .nib_code(nib_code), .smp_out(smp_out), .step_idx(step_idx)
    );

    function automatic int ref_mag(input int row, input int k);
        int v[8];
        case (row)
            0:  v = '{0, 0, 1, 2, 3, 5, 7, 10};
            1:  v = '{0, 1, 2, 3, 4, 6, 8, 13};
            2:  v = '{0, 1, 2, 4, 5, 7, 10, 15};
            3:  v = '{0, 1, 3, 4, 6, 9, 13, 19};
            4:  v = '{0, 2, 3, 5, 8, 11, 15, 23};
            5:  v = '{0, 2, 4, 7, 10, 14, 19, 29};
            6:  v = '{0, 3, 5, 8, 12, 16, 22, 33};
            7:  v = '{1, 4, 7, 10, 15, 20, 29, 43};
            8:  v = '{1, 4, 8, 13, 18, 25, 35, 53};
            9:  v = '{1, 6, 10, 16, 22, 31, 43, 64};
            10: v = '{2, 7, 12, 19, 27, 37, 51, 76};
            11: v = '{2, 9, 16, 24, 34, 46, 64, 96};
            12: v = '{3, 11, 19, 29, 41, 57, 79, 117};
            13: v = '{4, 13, 24, 36, 50, 69, 96, 143};
            14: v = '{4, 16, 29, 44, 62, 85, 118, 175};
            default: v = '{6, 20, 36, 54, 76, 104, 144, 214};
        endcase
        return v[k];
    endfunction

    function automatic int ref_adj(input int k);
        if (k <= 1) return -1;
        if (k <= 3) return 0;
        if (k == 4) return 1;
        if (k <= 6) return 2;
        return 3;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input bit v, input int c, input bit cl, input string tag);
        int d;
        nib_vld  = v;
        nib_code = 4'(c);
        clr      = cl;
        @(negedge clk);
        if (cl) begin
            m_smp = 0;
            m_idx = 0;
        end else if (v) begin
            d = ref_mag(m_idx, c & 7);
            if (c >= 8) d = -d;
            m_smp = m_smp + 16'(d);
            m_idx = m_idx + ref_adj(c & 7);
            if (m_idx < 0)  m_idx = 0;
            if (m_idx > 15) m_idx = 15;
        end
        check({tag, " sample"}, int'(smp_out), int'(m_smp));
        check({tag, " index"}, int'(step_idx), m_idx);
        nib_vld = 1'b0;
        clr     = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; nib_vld = 1'b0; nib_code = 4'd0;
        m_smp = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        check("R1 reset sample", int'(smp_out), 0);
        check("R1 reset index", int'(step_idx), 0);
        rst_n = 1'b1;
        step(1'b0, 5, 1'b0, "R1 idle hold");

        // R2 R5 R8: every row against every code.
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b0, 0, 1'b1, "R6 clear");
                for (int n = 0; n < r; n++) step(1'b1, 4, 1'b0, "R3 climb");
                step(1'b1, c, 1'b0, "R2 R5 R8 sweep");
            end
        end

        // R4: ceiling and floor.
        for (int n = 0; n < 10; n++) step(1'b1, 15, 1'b0, "R4 ceiling");
        check("R4 at top", int'(step_idx), 15);
        for (int n = 0; n < 20; n++) step(1'b1, 8, 1'b0, "R4 floor");
        check("R4 at bottom", int'(step_idx), 0);

        // R7: no strobe, inputs wiggle.
        for (int n = 0; n < 6; n++) step(1'b1, 7, 1'b0, "R3 up");
        for (int c = 0; c < 16; c++) step(1'b0, c, 1'b0, "R7 hold");

        // R6: clear beats a valid code.
        step(1'b1, 7, 1'b1, "R6 clear wins");

        // R9: drive past positive full scale at row 15.
        for (int n = 0; n < 200; n++) step(1'b1, 7, 1'b0, "R9 wrap");
        step(1'b0, 0, 1'b1, "R6 clear");
        for (int n = 0; n < 200; n++) step(1'b1, 15, 1'b0, "R9 wrap neg");

        // Random codes with occasional clears.
        for (int n = 0; n < 4000; n++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            step(rng[4] | rng[5], int'(rng[3:0]), rng[11:6] == 6'd0, "R2 R3 R4 random");
        end

        // R1: reset in mid-stream.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset sample", int'(smp_out), 0);
        check("R1 mid reset index", int'(step_idx), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule